// File: doc/BRIEF.md
# Speculative Protected-Line Tracker

This block keeps the set of cache lines that a core has placed under protection during a speculative region. Every entry holds a line address and an ownership flag. The flag is clear when the line is only read-protected and set once the line has been written or watched for writes. An entry can also hold an undo copy, which is the line's value from before its first speculative write. Any entry can match a given address, because the entries are searched in parallel. All addresses are line addresses, so two requests name the same line only when every address bit is equal.

Remote probes arrive as an address plus an access kind. They are compared with the tracked lines using a requester-wins rule. A probe that conflicts is never refused; it aborts the local region. The region also aborts when a new distinct line is requested while every entry is in use, and when the core asks for an abort itself. A commit drops every entry without further work. An abort starts a drain: the undo copies are presented on a restore port one per cycle as address/data pairs, and after the last pair the buffer empties.

Top module: `spec_line_buf`

## Requirements
- R1: After reset the buffer is empty, `abort_pulse` is low and `restore_valid` is low.
- R2: A probe or local request names the same line as an entry only if all `ADDR_W` address bits are equal. A line that differs in bit 0 is a different line.
- R3: For a read-protected entry (local op code 0 = protect-read), probe kinds 0 (read) and 2 (prefetch) cause no abort. Kinds 1 (write) and 3 (prefetch-for-write) make `abort_pulse` high in the cycle after the probe, with `abort_reason` 0 (contention).
- R4: For an owned entry (local op code 1 = protect-write or 2 = watch-for-write), every probe kind 0 to 3 aborts with reason 0. Probe kind 4 (remote commit) never aborts, whatever the entry's state.
- R5: `ENTRIES` distinct lines can be protected. A protect request (op 0, 1 or 2) for a further distinct line while all entries are used aborts with reason 1 (capacity). A request for a line already held does not.
- R6: A second protect request to a held line takes no new entry. A write or watch-for-write request upgrades a read-protected line to owned.
- R7: The first protect-write to a line stores `loc_old_data` as its undo copy. Later writes to the same line leave that copy unchanged.
- R8: After any abort, the undo copies of written lines appear on `restore_*` one per cycle in ascending entry order, the first one in the same cycle as `abort_pulse`. One idle cycle follows, and after it no line is held.
- R9: Local op 4 (commit) empties the buffer with no abort pulse and no restore beats.
- R10: Local op 3 (release) removes a held line that has no undo copy. Releasing a line that has an undo copy, or a line that is not held, changes nothing.
- R11: Local op 5 (abort) aborts with reason 2 (explicit).
- R12: A probe is judged against the entries as they stand before that cycle's local op. When the probe conflicts it wins: the reason is contention and the local op is dropped.
- R13: While a drain is in progress, local ops and probes are ignored.
- R14: `abort_pulse` lasts exactly one cycle per abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 3 | Local op code: 0 protect-read, 1 protect-write, 2 watch-for-write, 3 release, 4 commit, 5 abort |
| loc_addr | input | ADDR_W | Line address of the local request |
| loc_old_data | input | DATA_W | Line value before the write, used by protect-write |
| prb_valid | input | 1 | Remote probe present |
| prb_type | input | 3 | Probe kind: 0 read, 1 write, 2 prefetch, 3 prefetch-for-write, 4 commit |
| prb_addr | input | ADDR_W | Line address of the probe |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_reason | output | 2 | 0 contention, 1 capacity, 2 explicit |
| restore_valid | output | 1 | Restore pair valid |
| restore_addr | output | ADDR_W | Line to restore |
| restore_data | output | DATA_W | Value to write back |

## Verification
The functions that can land in the same cycle are a remote probe and a local request: a commit, a local abort, or a protect request for the line being probed. The bench presents both in one cycle. It then checks that a conflicting probe overrides a commit, reports contention, and leaves the lines in place for the restore drain. It also checks that a probe to a line being allocated in that same cycle sees no entry, and that the allocation still takes effect, which a later probe confirms. Probes and local requests sent during a drain are checked in the same way: they must leave no trace.

// File: rtl/slb_pkg.sv
package slb_pkg;

   typedef enum logic [2:0] {
      LOP_READ    = 3'd0,
      LOP_WRITE   = 3'd1,
      LOP_WATCHW  = 3'd2,
      LOP_RELEASE = 3'd3,
      LOP_COMMIT  = 3'd4,
      LOP_ABORT   = 3'd5
   } loc_op_e;

   typedef enum logic [2:0] {
      PRB_READ   = 3'd0,
      PRB_WRITE  = 3'd1,
      PRB_PREF   = 3'd2,
      PRB_PREFW  = 3'd3,
      PRB_COMMIT = 3'd4
   } prb_kind_e;

   typedef enum logic [1:0] {
      ABR_CONTENTION = 2'd0,
      ABR_CAPACITY   = 2'd1,
      ABR_EXPLICIT   = 2'd2
   } abort_why_e;

   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_DRAIN = 1'b1
   } slb_state_e;

   // probe kinds that hit even a read-only protected line
   function automatic logic prb_write_class(input logic [2:0] kind);
      return (kind == PRB_WRITE) || (kind == PRB_PREFW);
   endfunction

   // probe kinds that hit only an owned line
   function automatic logic prb_read_class(input logic [2:0] kind);
      return (kind == PRB_READ) || (kind == PRB_PREF);
   endfunction

   function automatic logic lop_is_protect(input logic [2:0] op);
      return (op == LOP_READ) || (op == LOP_WRITE) || (op == LOP_WATCHW);
   endfunction

endpackage

// File: rtl/slb_first_set.sv
module slb_first_set #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);

   if (N < 2) begin : g_bad_n
      $error("slb_first_set: N must be at least 2");
   end

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

   assign any_o = |vec_i;

endmodule

// File: rtl/slb_entry.sv
module slb_entry #(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] loc_addr_i,
   input  logic [DATA_W-1:0] old_data_i,
   input  logic [ADDR_W-1:0] prb_addr_i,
   input  logic              prb_en_i,
   input  logic              prb_wr_class_i,
   input  logic              prb_rd_class_i,
   input  logic              new_i,
   input  logic              upd_i,
   input  logic              set_owned_i,
   input  logic              set_save_i,
   input  logic              drop_i,
   input  logic              drop_all_i,
   output logic              valid_o,
   output logic              dirty_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              loc_hit_o,
   output logic              conflict_o
);

   logic              valid_q, owned_q, dirty_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign loc_hit_o  = valid_q && (addr_q == loc_addr_i);
   assign conflict_o = prb_en_i && valid_q && (addr_q == prb_addr_i) &&
                       (prb_wr_class_i || (owned_q && prb_rd_class_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         owned_q <= 1'b0;
         dirty_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (drop_all_i) begin
         valid_q <= 1'b0;
         owned_q <= 1'b0;
         dirty_q <= 1'b0;
      end else if (new_i) begin
         valid_q <= 1'b1;
         addr_q  <= loc_addr_i;
         owned_q <= set_owned_i;
         dirty_q <= set_save_i;
         data_q  <= old_data_i;
      end else if (drop_i) begin
         valid_q <= 1'b0;
         owned_q <= 1'b0;
         dirty_q <= 1'b0;
      end else if (upd_i) begin
         owned_q <= owned_q | set_owned_i;
         if (set_save_i && !dirty_q) begin
            dirty_q <= 1'b1;
            data_q  <= old_data_i;
         end
      end
   end

   assign valid_o = valid_q;
   assign dirty_o = dirty_q;
   assign addr_o  = addr_q;
   assign data_o  = data_q;

   // R7: an undo copy is never overwritten while its line stays held
   assert_undo_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && dirty_q && !drop_all_i && !new_i) |=> $stable(data_q));

   // R10: the controller only releases lines without an undo copy
   assert_release_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_i && !drop_all_i) |-> !dirty_q);

endmodule

// File: rtl/spec_line_buf.sv
module spec_line_buf #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 26,
   parameter int DATA_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_valid,
   input  logic [2:0]        loc_op,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic [DATA_W-1:0] loc_old_data,
   input  logic              prb_valid,
   input  logic [2:0]        prb_type,
   input  logic [ADDR_W-1:0] prb_addr,
   output logic              abort_pulse,
   output logic [1:0]        abort_reason,
   output logic              restore_valid,
   output logic [ADDR_W-1:0] restore_addr,
   output logic [DATA_W-1:0] restore_data
);
   import slb_pkg::*;

   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("spec_line_buf: ENTRIES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("spec_line_buf: widths must be positive");
   end

   slb_state_e        state_q;
   logic [ENTRIES-1:0] pending_q;

   logic [ENTRIES-1:0] valid_v, dirty_v, hit_v, confl_v;
   logic [ADDR_W-1:0]  ent_addr [ENTRIES];
   logic [DATA_W-1:0]  ent_data [ENTRIES];

   logic [IW-1:0] free_idx, drn_idx;
   logic          free_any, drn_any;

   logic accept, prb_en, contention, lop_go, hit_any;
   logic cap_abort, expl_abort, commit_go, abort_now;
   logic alloc_go, upd_go, rel_go, drop_all;
   logic set_owned, set_save;

   slb_first_set #(.N(ENTRIES), .IW(IW)) u_free (
      .vec_i (~valid_v),
      .idx_o (free_idx),
      .any_o (free_any)
   );

   slb_first_set #(.N(ENTRIES), .IW(IW)) u_drain (
      .vec_i (pending_q),
      .idx_o (drn_idx),
      .any_o (drn_any)
   );

   always_comb begin
      accept     = (state_q == ST_RUN);
      prb_en     = accept && prb_valid;
      contention = |confl_v;
      hit_any    = |hit_v;
      lop_go     = accept && loc_valid && !contention;
      cap_abort  = lop_go && lop_is_protect(loc_op) && !hit_any && !free_any;
      expl_abort = lop_go && (loc_op == LOP_ABORT);
      commit_go  = lop_go && (loc_op == LOP_COMMIT);
      abort_now  = contention || cap_abort || expl_abort;
      alloc_go   = lop_go && lop_is_protect(loc_op) && !hit_any && free_any;
      upd_go     = lop_go && lop_is_protect(loc_op) && hit_any;
      rel_go     = lop_go && (loc_op == LOP_RELEASE);
      set_owned  = (loc_op == LOP_WRITE) || (loc_op == LOP_WATCHW);
      set_save   = (loc_op == LOP_WRITE);
      drop_all   = commit_go || ((state_q == ST_DRAIN) && !drn_any);
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      slb_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ent (
         .clk            (clk),
         .rst_n          (rst_n),
         .loc_addr_i     (loc_addr),
         .old_data_i     (loc_old_data),
         .prb_addr_i     (prb_addr),
         .prb_en_i       (prb_en),
         .prb_wr_class_i (prb_write_class(prb_type)),
         .prb_rd_class_i (prb_read_class(prb_type)),
         .new_i          (alloc_go && (free_idx == IW'(g))),
         .upd_i          (upd_go && hit_v[g]),
         .set_owned_i    (set_owned),
         .set_save_i     (set_save),
         .drop_i         (rel_go && hit_v[g] && !dirty_v[g]),
         .drop_all_i     (drop_all),
         .valid_o        (valid_v[g]),
         .dirty_o        (dirty_v[g]),
         .addr_o         (ent_addr[g]),
         .data_o         (ent_data[g]),
         .loc_hit_o      (hit_v[g]),
         .conflict_o     (confl_v[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_RUN;
         pending_q    <= '0;
         abort_pulse  <= 1'b0;
         abort_reason <= ABR_CONTENTION;
      end else begin
         abort_pulse <= abort_now;
         if (abort_now) begin
            state_q   <= ST_DRAIN;
            pending_q <= valid_v & dirty_v;
            if (contention)     abort_reason <= ABR_CONTENTION;
            else if (cap_abort) abort_reason <= ABR_CAPACITY;
            else                abort_reason <= ABR_EXPLICIT;
         end else if (state_q == ST_DRAIN) begin
            if (drn_any) pending_q <= pending_q & ~(ENTRIES'(1) << drn_idx);
            else         state_q   <= ST_RUN;
         end
      end
   end

   assign restore_valid = (state_q == ST_DRAIN) && drn_any;
   assign restore_addr  = ent_addr[drn_idx];
   assign restore_data  = ent_data[drn_idx];

   // R14: one pulse per abort
   assert_pulse_single_R14: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !abort_pulse);

   // R6: a line is held by at most one entry
   assert_one_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));

   // R9: commit leaves nothing held
   assert_commit_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      commit_go |=> (valid_v == '0));

   // R5: a capacity abort only when every entry was in use
   assert_cap_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_pulse && abort_reason == ABR_CAPACITY) |-> $past(&valid_v));

   // R13: during a drain the held set only empties, never grows
   assert_drain_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN) |=> ((valid_v == $past(valid_v)) || (valid_v == '0)));

   // R8: every restore beat comes from a held, written line
   assert_restore_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> (valid_v[drn_idx] && dirty_v[drn_idx]));

endmodule

// File: tb/spec_line_buf_test.sv
`timescale 1ns/1ps
module spec_line_buf_test;

   localparam int NE = 4;
   localparam int AW = 8;
   localparam int DW = 16;

   localparam logic [2:0] L_RD = 3'd0, L_WR = 3'd1, L_WW = 3'd2,
                          L_REL = 3'd3, L_CMT = 3'd4, L_ABT = 3'd5;
   localparam logic [2:0] P_RD = 3'd0, P_WR = 3'd1, P_PF = 3'd2,
                          P_PFW = 3'd3, P_CMT = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic loc_valid = 1'b0;
   logic [2:0] loc_op = '0;
   logic [AW-1:0] loc_addr = '0;
   logic [DW-1:0] loc_old_data = '0;
   logic prb_valid = 1'b0;
   logic [2:0] prb_type = '0;
   logic [AW-1:0] prb_addr = '0;
   logic abort_pulse;
   logic [1:0] abort_reason;
   logic restore_valid;
   logic [AW-1:0] restore_addr;
   logic [DW-1:0] restore_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   spec_line_buf #(.ENTRIES(NE), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .loc_valid(loc_valid), .loc_op(loc_op), .loc_addr(loc_addr),
      .loc_old_data(loc_old_data),
      .prb_valid(prb_valid), .prb_type(prb_type), .prb_addr(prb_addr),
      .abort_pulse(abort_pulse), .abort_reason(abort_reason),
      .restore_valid(restore_valid), .restore_addr(restore_addr),
      .restore_data(restore_data)
   );

   function automatic logic [DW-1:0] od(input logic [AW-1:0] a);
      return DW'(a * 97 + 3);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic lv, input logic [2:0] lop, input logic [AW-1:0] la,
                        input logic [DW-1:0] ld, input logic pv, input logic [2:0] pt,
                        input logic [AW-1:0] pa);
      @(negedge clk);
      loc_valid = lv; loc_op = lop; loc_addr = la; loc_old_data = ld;
      prb_valid = pv; prb_type = pt; prb_addr = pa;
      @(posedge clk);
      #1;
      loc_valid = 1'b0;
      prb_valid = 1'b0;
   endtask

   task automatic loc(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      drive(1'b1, op, a, d, 1'b0, P_RD, '0);
   endtask

   task automatic prb(input logic [2:0] t, input logic [AW-1:0] a);
      drive(1'b0, L_RD, '0, '0, 1'b1, t, a);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse(input string tag, input logic exp, input logic [1:0] why);
      check({tag, " pulse"}, abort_pulse, exp);
      if (exp) check({tag, " reason"}, abort_reason, why);
   endtask

   task automatic rchk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
      check({tag, " rvalid"}, restore_valid, 1'b1);
      check({tag, " raddr"}, restore_addr, a);
      check({tag, " rdata"}, restore_data, d);
   endtask

   task automatic beat(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
      rchk(tag, a, d);
      step();
   endtask

   task automatic drain_end(input string tag);
      check({tag, " drain end"}, restore_valid, 1'b0);
      step();
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      step();
      check("R1 reset pulse", abort_pulse, 1'b0);
      check("R1 reset restore", restore_valid, 1'b0);

      // R3 R4 R2: sweep over local state, probe kind and address match
      for (int lk = 0; lk < 3; lk++) begin
         for (int pt = 0; pt < 5; pt++) begin
            for (int m = 0; m < 2; m++) begin
               logic [2:0] op;
               logic [AW-1:0] a, pa;
               logic owned, exp;
               op = (lk == 0) ? L_RD : (lk == 1) ? L_WW : L_WR;
               a  = AW'(8'h40 + lk * 16 + pt * 2);
               pa = m ? a : (a ^ 8'h01);
               owned = (op != L_RD);
               exp = m && (pt == 1 || pt == 3 || (owned && (pt == 0 || pt == 2)));
               loc(op, a, od(a));
               prb(3'(pt), pa);
               pulse($sformatf("R3/R4 lk%0d pt%0d m%0d", lk, pt, m), exp, 2'd0);
               if (exp) begin
                  if (op == L_WR) beat("R8 sweep", a, od(a));
                  drain_end("R8 sweep");
               end else begin
                  loc(L_CMT, '0, '0);
               end
            end
         end
      end

      // R5 capacity and R14 single pulse
      for (int i = 1; i <= NE; i++) begin
         loc(L_RD, AW'(i), '0);
         pulse("R5 fill", 1'b0, 2'd0);
      end
      loc(L_WR, 8'd2, od(8'd2));
      pulse("R5 repeat line", 1'b0, 2'd0);
      loc(L_RD, 8'd5, '0);
      pulse("R5 overflow", 1'b1, 2'd1);
      beat("R5 restore", 8'd2, od(8'd2));
      check("R14 pulse dropped", abort_pulse, 1'b0);
      drain_end("R5");

      // R7 R8 R11: undo copies and ascending drain order
      loc(L_WR, 8'd10, od(8'd10));
      loc(L_WR, 8'd20, od(8'd20));
      loc(L_RD, 8'd30, '0);
      loc(L_WR, 8'd40, od(8'd40));
      loc(L_WR, 8'd20, od(8'd20) ^ 16'hFFFF);
      loc(L_WR, 8'd30, od(8'd30));
      loc(L_ABT, '0, '0);
      pulse("R11 explicit", 1'b1, 2'd2);
      beat("R8 e0", 8'd10, od(8'd10));
      beat("R7 first copy kept", 8'd20, od(8'd20));
      beat("R8 e2", 8'd30, od(8'd30));
      beat("R8 e3", 8'd40, od(8'd40));
      drain_end("R8");
      for (int i = 0; i < NE; i++) begin
         loc(L_RD, AW'(100 + i), '0);
         pulse("R8 emptied after drain", 1'b0, 2'd0);
      end
      loc(L_CMT, '0, '0);

      // R6 upgrade
      loc(L_RD, 8'd50, '0);
      prb(P_RD, 8'd50);
      pulse("R6 shared read ok", 1'b0, 2'd0);
      loc(L_WR, 8'd50, od(8'd50));
      prb(P_PF, 8'd50);
      pulse("R6 upgraded to owned", 1'b1, 2'd0);
      beat("R6 restore", 8'd50, od(8'd50));
      drain_end("R6");
      loc(L_RD, 8'd50, '0);
      loc(L_WR, 8'd50, od(8'd50));
      loc(L_RD, 8'd51, '0);
      loc(L_RD, 8'd52, '0);
      loc(L_RD, 8'd53, '0);
      pulse("R6 no extra entry", 1'b0, 2'd0);
      loc(L_CMT, '0, '0);

      // R10 release
      for (int i = 1; i <= NE; i++) loc(L_RD, AW'(i), '0);
      loc(L_REL, 8'd3, '0);
      loc(L_REL, 8'd99, '0);
      loc(L_RD, 8'd7, '0);
      pulse("R10 freed slot reused", 1'b0, 2'd0);
      prb(P_WR, 8'd3);
      pulse("R10 released line unmonitored", 1'b0, 2'd0);
      loc(L_CMT, '0, '0);
      loc(L_WR, 8'd60, od(8'd60));
      loc(L_REL, 8'd60, '0);
      prb(P_WR, 8'd60);
      pulse("R10 written line kept", 1'b1, 2'd0);
      beat("R10 restore", 8'd60, od(8'd60));
      drain_end("R10");

      // R9 commit
      loc(L_WR, 8'd70, od(8'd70));
      loc(L_WR, 8'd71, od(8'd71));
      loc(L_CMT, '0, '0);
      pulse("R9 commit no pulse", 1'b0, 2'd0);
      check("R9 commit no restore", restore_valid, 1'b0);
      prb(P_WR, 8'd70);
      pulse("R9 emptied", 1'b0, 2'd0);

      // R4 remote commit on owned line
      loc(L_WR, 8'd72, od(8'd72));
      prb(P_CMT, 8'd72);
      pulse("R4 remote commit", 1'b0, 2'd0);
      loc(L_CMT, '0, '0);

      // R12 same-cycle probe and local op
      loc(L_RD, 8'd30, '0);
      drive(1'b1, L_CMT, '0, '0, 1'b1, P_WR, 8'd30);
      pulse("R12 probe beats commit", 1'b1, 2'd0);
      drain_end("R12 a");
      drive(1'b1, L_WR, 8'd31, od(8'd31), 1'b1, P_RD, 8'd31);
      pulse("R12 probe sees old entries", 1'b0, 2'd0);
      prb(P_RD, 8'd31);
      pulse("R12 allocation took effect", 1'b1, 2'd0);
      beat("R12 restore", 8'd31, od(8'd31));
      drain_end("R12 b");

      // R13 inputs ignored while draining
      loc(L_WR, 8'd10, od(8'd10));
      loc(L_WR, 8'd20, od(8'd20));
      loc(L_ABT, '0, '0);
      pulse("R13 abort", 1'b1, 2'd2);
      rchk("R13 beat0", 8'd10, od(8'd10));
      drive(1'b1, L_RD, 8'd90, '0, 1'b1, P_WR, 8'd20);
      pulse("R13 probe ignored", 1'b0, 2'd0);
      rchk("R13 beat1", 8'd20, od(8'd20));
      step();
      drain_end("R13");
      prb(P_WR, 8'd90);
      pulse("R13 local op dropped", 1'b0, 2'd0);
      prb(P_WR, 8'd10);
      pulse("R8 cleared after drain", 1'b0, 2'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule